// File: doc/BRIEF.md
# Driver Strength Calibration Sequencer

This block keeps the strength code of an output driver made of binary-weighted legs matched to an external reference resistor. A free-running cycle counter raises an evaluation request once per period. An analog comparator outside the block then reports whether the driver is currently too strong or too weak. Each report that answers an outstanding request moves the code by exactly one step toward the target. The code therefore creeps to its setting rather than jumping there in one search.

The periodic evaluations start right after reset and never stop. This lets the code follow slow supply and temperature drift for as long as the clock runs. A separate start-up timer counts a long interval from reset, whatever the comparator is doing. When that interval ends, the block raises a calibrated flag. The flag tells downstream logic that enough single-step evaluations have run for the code to be trusted.

Top module: `drive_cal_ctrl`

## Requirements
- R1: While reset is asserted, the code equals mid-scale (only the top bit of the code set, 8 for a 4-bit code), the evaluation request is low and the calibrated flag is low.
- R2: The evaluation request is a pulse of one cycle. It is high in the cycle after the PERIOD-th rising edge following reset release, and again every PERIOD cycles after that, for as long as the clock runs.
- R3: The calibrated flag is low until STARTUP rising edges have passed since reset release. It is high from then on until the next reset.
- R4: A comparator result taken with `cmp_strong_i` = 1 (too strong) lowers the code by one. A result taken with `cmp_strong_i` = 0 (too weak) raises the code by one. The new code appears in the cycle after the valid strobe was sampled.
- R5: A request stays outstanding from its pulse cycle until a result is taken. A result is taken only when the valid strobe is high while a request is outstanding. A valid strobe with no outstanding request leaves the code unchanged, so each request moves the code by at most one step, even if the valid strobe is held high.
- R6: The code saturates. A too-strong result at 0 keeps it at 0, and a too-weak result at all ones keeps it at all ones. It never wraps.
- R7: Evaluations and code updates continue after the calibrated flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_valid_i | input | 1 | Comparator result valid strobe |
| cmp_strong_i | input | 1 | Comparator result: 1 = driver too strong, 0 = too weak |
| code_o | output | CODE_W | Driver strength code, binary weighted |
| eval_req_o | output | 1 | One-cycle evaluation request pulse |
| calibrated_o | output | 1 | Start-up interval finished, sticky until reset |

## Verification
The bench builds the block with a 4-bit code, a 16-cycle period and a 200-cycle start-up count, instead of the 32768-cycle default. With these values the calibrated edge, both code rails, and many evaluations before and after calibration all fall within a short run. A strobe held high for hundreds of cycles shows that each request gives only one step. Strobes driven only when no request is pending show that such results are dropped. A second reset in mid-run checks that the flag and the code return to their reset values.

// File: rtl/drive_cal_pkg.sv
package drive_cal_pkg;

  // One saturating step toward the target: too strong lowers, too weak raises.
  function automatic int unsigned cal_step(int unsigned cur, logic too_strong,
                                           int unsigned top);
    if (too_strong) return (cur == 0) ? 0 : cur - 1;
    return (cur >= top) ? top : cur + 1;
  endfunction

  function automatic int unsigned cal_mid(int unsigned width);
    return 1 << (width - 1);
  endfunction

endpackage

// File: rtl/drive_cal_startup.sv
module drive_cal_startup #(
  parameter int unsigned STARTUP = 32768
) (
  input  logic clk,
  input  logic rst_n,
  output logic done_o
);
  localparam int unsigned SW = $clog2(STARTUP + 1);
  localparam logic [SW-1:0] LAST = SW'(STARTUP - 1);

  logic [SW-1:0] cnt_q;
  logic          done_q;
  logic          hit_w;

  assign hit_w = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q  <= cnt_q + 1'b1;
      done_q <= hit_w;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/drive_cal_period.sv
module drive_cal_period #(
  parameter int unsigned PERIOD = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic wrap_o,
  output logic req_o
);
  localparam int unsigned PW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] cnt_q;
  logic          req_q;

  assign wrap_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
      req_q <= wrap_o;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/drive_cal_stepper.sv
module drive_cal_stepper
  import drive_cal_pkg::*;
#(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_i,
  input  logic              cmp_valid_i,
  input  logic              cmp_strong_i,
  output logic [CODE_W-1:0] code_o,
  output logic              pending_o,
  output logic              accept_o
);
  localparam int unsigned TOP = (1 << CODE_W) - 1;
  localparam logic [CODE_W-1:0] MID = CODE_W'(cal_mid(CODE_W));

  logic [CODE_W-1:0] code_q;
  logic              pend_q;

  assign accept_o = cmp_valid_i & pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= MID;
      pend_q <= 1'b0;
    end else begin
      pend_q <= wrap_i | (pend_q & ~accept_o);
      if (accept_o)
        code_q <= CODE_W'(cal_step(int'(code_q), cmp_strong_i, TOP));
    end
  end

  assign code_o    = code_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/drive_cal_ctrl.sv
module drive_cal_ctrl #(
  parameter int unsigned CODE_W  = 5,
  parameter int unsigned PERIOD  = 1024,
  parameter int unsigned STARTUP = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid_i,
  input  logic              cmp_strong_i,
  output logic [CODE_W-1:0] code_o,
  output logic              eval_req_o,
  output logic              calibrated_o
);
  logic wrap_w;
  logic pend_w;
  logic acc_w;

  drive_cal_startup #(.STARTUP(STARTUP)) u_startup (
    .clk(clk), .rst_n(rst_n), .done_o(calibrated_o)
  );

  drive_cal_period #(.PERIOD(PERIOD)) u_period (
    .clk(clk), .rst_n(rst_n), .wrap_o(wrap_w), .req_o(eval_req_o)
  );

  drive_cal_stepper #(.CODE_W(CODE_W)) u_step (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap_w),
    .cmp_valid_i(cmp_valid_i), .cmp_strong_i(cmp_strong_i),
    .code_o(code_o), .pending_o(pend_w), .accept_o(acc_w)
  );
endmodule

// File: rtl/drive_cal_chk.sv
module drive_cal_chk #(
  parameter int unsigned CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] code,
  input logic              req,
  input logic              cal,
  input logic              pending,
  input logic              accept,
  input logic              cmp_strong
);
  localparam logic [CODE_W-1:0] TOPV = '1;

  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

  p_req_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> pending);

  p_cal_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cal |=> cal);

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmp_strong && code != '0) |=> code == $past(code) - 1'b1);

  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmp_strong && code != TOPV) |=> code == $past(code) + 1'b1);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(code));

  p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmp_strong && code == '0) |=> code == '0);

  p_ceil_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmp_strong && code == TOPV) |=> code == TOPV);
endmodule

bind drive_cal_ctrl drive_cal_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .code(code_o), .req(eval_req_o),
  .cal(calibrated_o), .pending(pend_w), .accept(acc_w),
  .cmp_strong(cmp_strong_i)
);

// File: tb/drive_cal_ctrl_tb_top.sv
module drive_cal_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 4;
  localparam int PER = 16;
  localparam int SU  = 200;
  localparam int MAXV = (1 << CW) - 1;
  localparam int MIDV = 1 << (CW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_valid = 1'b0;
  logic cmp_strong = 1'b0;
  logic [CW-1:0] code;
  logic req, cal;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int k = 0;
  bit pend = 0;
  int ecode = MIDV;

  always #(CLK_PERIOD/2) clk = ~clk;

  drive_cal_ctrl #(.CODE_W(CW), .PERIOD(PER), .STARTUP(SU)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_valid_i(cmp_valid),
    .cmp_strong_i(cmp_strong), .code_o(code), .eval_req_o(req),
    .calibrated_o(cal)
  );

  function automatic int exp_step(int c, bit s);
    if (s) return (c > 0) ? c - 1 : 0;
    return (c < MAXV) ? c + 1 : MAXV;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at k=%0d", tag, act, exp, k);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmp_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 code", int'(code), MIDV);
    chk("R1 req", int'(req), 0);
    chk("R1 cal", int'(cal), 0);
    rst_n = 1'b1;
    k = 0;
    pend = 0;
    ecode = MIDV;
  endtask

  task automatic cycle(bit v, bit s, string ctag);
    bit acc;
    chk(ctag, int'(code), ecode);
    chk("R2", int'(req), (k > 0 && k % PER == 0) ? 1 : 0);
    chk("R3", int'(cal), (k >= SU) ? 1 : 0);
    cmp_valid = v;
    cmp_strong = s;
    acc = v && pend;
    if (acc) ecode = exp_step(ecode, s);
    pend = ((k + 1) % PER == 0) || (pend && !acc);
    k++;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();
    // R4: random comparator traffic before calibration
    for (int i = 0; i < 150; i++) cycle(($urandom % 3) == 0, $urandom % 2, "R4");
    // R5: strobe held high, one step per request only
    for (int i = 0; i < 100; i++) cycle(1'b1, 1'b1, "R5");
    // R6: floor saturation, then ceiling saturation
    for (int i = 0; i < 250; i++) cycle(1'b1, 1'b1, "R6 floor");
    for (int i = 0; i < 350; i++) cycle(1'b1, 1'b0, "R6 ceil");
    for (int i = 0; i < 100; i++) cycle(1'b1, 1'b1, "R4 down");
    // R5: strobes only while no request is outstanding are ignored
    for (int i = 0; i < 200; i++) cycle(!pend, $urandom % 2, "R5 ignored");
    // R7: evaluation continues after calibration
    for (int i = 0; i < 300; i++) cycle(($urandom % 2) == 0, $urandom % 2, "R7");
    // second reset in mid-run
    do_reset();
    for (int i = 0; i < 40; i++) cycle(1'b1, $urandom % 2, "R4 after reset");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule